// File: doc/BRIEF.md
# Key-Guarded Reset Control Registers

This block is a small register file that decides which chip resets may be requested and what kind of reset each one becomes. Software reaches it through a plain 32-bit register port with three word addresses: a control word, a configuration word and a read-only status word. The control and configuration words are protected. Before each change, software must write an unlock code into the low half of the control word. The lock closes again after any write to either protected word, so every protected write needs its own unlock.

The block watches the external reset pin and a set of watchdog reset lines for rising edges. It also accepts a software reset request through bit 16 of the control word. Each source produces a one-cycle request pulse, and each has a type flag, taken from the configuration word, that marks the reset as hard (0) or soft (1). The status word records which source fired most recently. The synchronous power-on input clears every register. The reset requests the block issues clear only the lock and the software reset bit, so the configuration survives them.

Top module: `rst_lock_regs`

## Requirements
- R1: After power-on reset (input `rst`, synchronous, active high):
  - the control word (address 0) reads 0x00010003;
  - the configuration word (address 1) reads 0;
  - the status word (address 2) reads 0x00000001;
  - every request and type output is 0.
- R2: Only the value 0x5A69 in bits 15:0 of a control write unlocks the block while it is locked. Bits 15:0 of the control word then read 0x000C while unlocked and 0x0003 while locked. Any other value leaves the block locked.
- R3: A control write that unlocks the block leaves bit 16 unchanged and raises no request.
- R4: A write to address 0 or address 1 while unlocked relocks the block. A write to address 2 or address 3 does not change the lock.
- R5: A control write made while unlocked stores bit 16.
  - If bit 16 is 0, `req_sw` pulses high for exactly one cycle, and bit 16 reads 0 during that cycle.
  - If bit 16 is 1, no request is raised.
- R6: A configuration write made while unlocked stores bits 13, 12 and 3:0. All other bits read 0. A configuration write made while locked is ignored.
- R7: `type_sw` follows configuration bit 13, `type_pin` follows bit 12, and `type_wd[i]` follows bit i. The value 0 means hard reset and 1 means soft reset.
- R8: A rising edge on `rst_pin` gives a one-cycle `req_pin` pulse in the next cycle. A rising edge on `wd_rst[i]` gives a one-cycle `req_wd[i]` pulse. Holding an input high does not repeat the pulse.
- R9: The status word has exactly one bit set, marking the last source. The bit positions are:
  - bit 0: power-on reset;
  - bit 1: reset pin;
  - bit 2: software reset;
  - bit 8+i: watchdog i.

  When several sources fire in the same cycle, the pin wins, then the lowest-numbered watchdog, then software.
- R10: Control bits 31:17 always read 0. Writes to the status word change nothing.
- R11: The cycle after any request pulse, the block is relocked and control bit 16 returns to 1. The configuration word keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 2 | Word address: 0 control, 1 configuration, 2 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| rst_pin | input | 1 | External reset pin, active high |
| wd_rst | input | NUM_WD | Watchdog reset lines |
| req_pin | output | 1 | Reset request pulse from the pin |
| req_wd | output | NUM_WD | Reset request pulses from the watchdogs |
| req_sw | output | 1 | Software reset request pulse |
| type_pin | output | 1 | Pin reset type (1 = soft) |
| type_wd | output | NUM_WD | Watchdog reset types (1 = soft) |
| type_sw | output | 1 | Software reset type (1 = soft) |

## Verification
The lock is driven with the following control writes, which separate a one-bit-off compare from an exact compare and show whether the lock closes after every write:
- near-miss codes;
- the exact code;
- the code with reserved bits set;
- back-to-back protected writes.

Reset sources are tested singly, in simultaneous pairs and as held levels. Together these separate the priority order from edge detection. Software requests are issued both with bit 16 cleared and with it set, which shows whether the pulse depends on the written value rather than on the write alone.

// File: rtl/rstlk_pkg.sv
package rstlk_pkg;

    localparam int          MAX_WD      = 4;
    localparam logic [15:0] UNLOCK_CODE = 16'h5A69;
    localparam logic [15:0] KEY_OPEN_RD = 16'h000C;
    localparam logic [15:0] KEY_SHUT_RD = 16'h0003;
    localparam int          SWRST_BIT   = 16;
    localparam int          CFG_SW_BIT  = 13;
    localparam int          CFG_PIN_BIT = 12;
    localparam int          ST_POR      = 0;
    localparam int          ST_PIN      = 1;
    localparam int          ST_SW       = 2;
    localparam int          ST_WD0      = 8;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_CFG  = 2'd1,
        REG_STAT = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              pin;
        logic [MAX_WD-1:0] wd;
        logic              sw;
    } rst_evt_t;

    function automatic logic [31:0] cfg_mask(int nwd);
        logic [31:0] m;
        m = (32'd1 << CFG_SW_BIT) | (32'd1 << CFG_PIN_BIT);
        m = m | ((32'd1 << nwd) - 32'd1);
        return m;
    endfunction

    // One-hot status code; pin beats watchdogs (low index first), which beat software.
    function automatic logic [31:0] status_code(rst_evt_t e);
        logic [31:0] r;
        logic        found;
        r     = '0;
        found = 1'b0;
        if (e.pin) begin
            r[ST_PIN] = 1'b1;
        end else if (|e.wd) begin
            for (int i = 0; i < MAX_WD; i++) begin
                if (e.wd[i] && !found) begin
                    r[ST_WD0 + i] = 1'b1;
                    found         = 1'b1;
                end
            end
        end else if (e.sw) begin
            r[ST_SW] = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/rstlk_key_gate.sv
module rstlk_key_gate
    import rstlk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ctrl_wr,
    input  logic        cfg_wr,
    input  logic [16:0] ctrl_wdata,
    input  logic        relock,
    output logic        key_open,
    output logic        sw_bit,
    output logic        sw_fire
);

    assign sw_fire = ctrl_wr && key_open && !relock && !ctrl_wdata[SWRST_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            key_open <= 1'b0;
            sw_bit   <= 1'b1;
        end else if (relock) begin
            key_open <= 1'b0;
            sw_bit   <= 1'b1;
        end else if (ctrl_wr) begin
            if (key_open) begin
                sw_bit   <= ctrl_wdata[SWRST_BIT];
                key_open <= 1'b0;
            end else if (ctrl_wdata[15:0] == UNLOCK_CODE) begin
                key_open <= 1'b1;
            end
        end else if (cfg_wr) begin
            key_open <= 1'b0;
        end
    end

endmodule

// File: rtl/rstlk_cfg_reg.sv
module rstlk_cfg_reg
    import rstlk_pkg::*;
#(
    parameter int NUM_WD = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_ok,
    input  logic [31:0] wdata,
    output logic [31:0] cfg_q
);

    localparam logic [31:0] MASK = cfg_mask(NUM_WD);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_ok) begin
            cfg_q <= wdata & MASK;
        end
    end

endmodule

// File: rtl/rstlk_src_track.sv
module rstlk_src_track
    import rstlk_pkg::*;
#(
    parameter int NUM_WD = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin,
    input  logic [NUM_WD-1:0] wd,
    input  logic              sw_fire,
    output logic              req_pin,
    output logic [NUM_WD-1:0] req_wd,
    output logic              req_sw,
    output logic [31:0]       status_q
);

    logic              pin_q;
    logic              pin_edge;
    logic [NUM_WD-1:0] wd_edge;
    rst_evt_t          evt;

    assign pin_edge = pin & ~pin_q;

    for (genvar g = 0; g < NUM_WD; g++) begin : g_wd
        logic q;
        always_ff @(posedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= wd[g];
        end
        assign wd_edge[g] = wd[g] & ~q;
    end

    always_comb begin
        evt                = '0;
        evt.pin            = pin_edge;
        evt.sw             = sw_fire;
        evt.wd[NUM_WD-1:0] = wd_edge;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q    <= 1'b0;
            req_pin  <= 1'b0;
            req_wd   <= '0;
            req_sw   <= 1'b0;
            status_q <= 32'd1 << ST_POR;
        end else begin
            pin_q   <= pin;
            req_pin <= pin_edge;
            req_wd  <= wd_edge;
            req_sw  <= sw_fire;
            if (|evt) status_q <= status_code(evt);
        end
    end

endmodule

// File: rtl/rst_lock_regs.sv
module rst_lock_regs
    import rstlk_pkg::*;
#(
    parameter int NUM_WD = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              rst_pin,
    input  logic [NUM_WD-1:0] wd_rst,
    output logic              req_pin,
    output logic [NUM_WD-1:0] req_wd,
    output logic              req_sw,
    output logic              type_pin,
    output logic [NUM_WD-1:0] type_wd,
    output logic              type_sw
);

    reg_sel_e    sel;
    logic        ctrl_wr;
    logic        cfg_wr;
    logic        key_open;
    logic        sw_bit;
    logic        sw_fire;
    logic        relock;
    logic [31:0] cfg_q;
    logic [31:0] status_q;

    assign sel     = reg_sel_e'(bus_addr);
    assign ctrl_wr = bus_we && (sel == REG_CTRL);
    assign cfg_wr  = bus_we && (sel == REG_CFG);
    assign relock  = req_pin | req_sw | (|req_wd);

    rstlk_key_gate u_key (
        .clk        (clk),
        .rst        (rst),
        .ctrl_wr    (ctrl_wr),
        .cfg_wr     (cfg_wr),
        .ctrl_wdata (bus_wdata[16:0]),
        .relock     (relock),
        .key_open   (key_open),
        .sw_bit     (sw_bit),
        .sw_fire    (sw_fire)
    );

    rstlk_cfg_reg #(.NUM_WD(NUM_WD)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr_ok (cfg_wr && key_open && !relock),
        .wdata (bus_wdata),
        .cfg_q (cfg_q)
    );

    rstlk_src_track #(.NUM_WD(NUM_WD)) u_src (
        .clk      (clk),
        .rst      (rst),
        .pin      (rst_pin),
        .wd       (wd_rst),
        .sw_fire  (sw_fire),
        .req_pin  (req_pin),
        .req_wd   (req_wd),
        .req_sw   (req_sw),
        .status_q (status_q)
    );

    assign type_sw  = cfg_q[CFG_SW_BIT];
    assign type_pin = cfg_q[CFG_PIN_BIT];
    assign type_wd  = cfg_q[NUM_WD-1:0];

    always_comb begin
        case (sel)
            REG_CTRL: bus_rdata = {15'd0, sw_bit, key_open ? KEY_OPEN_RD : KEY_SHUT_RD};
            REG_CFG:  bus_rdata = cfg_q;
            REG_STAT: bus_rdata = status_q;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/rstlk_chk.sv
module rstlk_chk #(
    parameter int NUM_WD = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [1:0]        bus_addr,
    input logic              key_open,
    input logic              sw_bit,
    input logic [31:0]       cfg_q,
    input logic [31:0]       status_q,
    input logic              req_pin,
    input logic              req_sw,
    input logic [NUM_WD-1:0] req_wd
);

    a_r4_relock_after_write: assert property (@(posedge clk) disable iff (rst)
        key_open && bus_we && (bus_addr <= 2'd1) |=> !key_open);

    a_r6_locked_cfg_held: assert property (@(posedge clk) disable iff (rst)
        !key_open && bus_we && (bus_addr == 2'd1) |=> $stable(cfg_q));

    a_r8_pin_single_pulse: assert property (@(posedge clk) disable iff (rst)
        req_pin |=> !req_pin);

    a_r5_sw_single_pulse: assert property (@(posedge clk) disable iff (rst)
        req_sw |=> !req_sw);

    a_r9_status_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones(status_q) == 1);

    a_r9_pin_wins: assert property (@(posedge clk) disable iff (rst)
        req_pin |-> status_q[1]);

    a_r11_relock_on_request: assert property (@(posedge clk) disable iff (rst)
        (req_pin || req_sw || (|req_wd)) |=> (!key_open && sw_bit && $stable(cfg_q)));

endmodule

bind rst_lock_regs rstlk_chk #(.NUM_WD(NUM_WD)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .key_open (key_open),
    .sw_bit   (sw_bit),
    .cfg_q    (cfg_q),
    .status_q (status_q),
    .req_pin  (req_pin),
    .req_sw   (req_sw),
    .req_wd   (req_wd)
);

// File: tb/tb_rst_lock_regs.sv
`timescale 1ns/1ps
module tb_rst_lock_regs;

    localparam int NW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_we = 1'b0;
    logic [1:0]    bus_addr = 2'd0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          rst_pin = 1'b0;
    logic [NW-1:0] wd_rst = '0;
    logic          req_pin, req_sw, type_pin, type_sw;
    logic [NW-1:0] req_wd, type_wd;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    rst_lock_regs #(.NUM_WD(NW)) dut (.*);

    // fields: wen[68] waddr[67:66] wdata[65:34] raddr[33:32] expect[31:0]
    localparam int NV = 14;
    localparam logic [68:0] VECS [NV] = '{
        {1'b1, 2'd0, 32'h0000_1234, 2'd0, 32'h0001_0003},  // R2 wrong code
        {1'b1, 2'd0, 32'h0000_5A6A, 2'd0, 32'h0001_0003},  // R2 near miss
        {1'b1, 2'd1, 32'hFFFF_FFFF, 2'd1, 32'h0000_0000},  // R6 locked cfg write
        {1'b1, 2'd0, 32'h0000_5A69, 2'd0, 32'h0001_000C},  // R2 R3 unlock
        {1'b1, 2'd1, 32'hFFFF_FFFF, 2'd1, 32'h0000_300F},  // R6 masked store
        {1'b0, 2'd0, 32'h0000_0000, 2'd0, 32'h0001_0003},  // R4 relocked by cfg write
        {1'b1, 2'd1, 32'h0000_0000, 2'd1, 32'h0000_300F},  // R6 locked again
        {1'b1, 2'd0, 32'hFFFF_5A69, 2'd0, 32'h0001_000C},  // R10 reserved bits
        {1'b1, 2'd0, 32'hFFFF_0000, 2'd0, 32'h0001_0003},  // R4 R5 bit16=1
        {1'b1, 2'd2, 32'hFFFF_FFFF, 2'd2, 32'h0000_0001},  // R10 status write
        {1'b1, 2'd0, 32'h0000_5A69, 2'd0, 32'h0001_000C},  // R2 unlock
        {1'b1, 2'd2, 32'h0000_0000, 2'd0, 32'h0001_000C},  // R4 status write keeps lock
        {1'b1, 2'd1, 32'h0000_2005, 2'd1, 32'h0000_2005},  // R6 partial store
        {1'b0, 2'd0, 32'h0000_0000, 2'd0, 32'h0001_0003}   // R4 relocked
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic reqs(input string tag, input logic [31:0] exp);
        check(tag, {26'd0, req_pin, req_sw, req_wd}, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rd(2'd0, v); check("R1 ctrl", v, 32'h0001_0003);
        rd(2'd1, v); check("R1 cfg", v, 32'h0);
        rd(2'd2, v); check("R1 status", v, 32'h1);
        reqs("R1 requests", 32'h0);
        check("R1 types", {29'd0, type_pin, type_sw, |type_wd}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i][68]) wr(VECS[i][67:66], VECS[i][65:34]);
            else @(negedge clk);
            reqs($sformatf("R3 no request vec %0d", i), 32'h0);
            rd(VECS[i][33:32], v);
            check($sformatf("R2/R4/R6/R10 vec %0d", i), v, VECS[i][31:0]);
        end

        // R7 types follow cfg 0x2005
        check("R7 types", {26'd0, type_pin, type_sw, type_wd}, {26'd0, 1'b0, 1'b1, 4'b0101});

        // R5 software request
        wr(2'd0, 32'h0000_5A69);
        wr(2'd0, 32'h0000_0000);
        reqs("R5 sw pulse", 32'h10);
        rd(2'd0, v); check("R5 bit16 low", v, 32'h0000_0003);
        @(negedge clk);
        reqs("R5 pulse ends", 32'h0);
        rd(2'd0, v); check("R11 bit16 restored", v, 32'h0001_0003);
        rd(2'd2, v); check("R9 sw status", v, 32'h4);
        rd(2'd1, v); check("R11 cfg kept", v, 32'h2005);

        // R8 R11 pin edge while unlocked
        wr(2'd0, 32'h0000_5A69);
        rst_pin = 1'b1;
        @(negedge clk);
        reqs("R8 pin pulse", 32'h20);
        rd(2'd2, v); check("R9 pin status", v, 32'h2);
        @(negedge clk);
        reqs("R8 held pin no repeat", 32'h0);
        rd(2'd0, v); check("R11 relock on pin", v, 32'h0001_0003);
        rst_pin = 1'b0;

        // R8 watchdog edge
        wd_rst = 4'b0100;
        @(negedge clk);
        reqs("R8 wd2 pulse", 32'h4);
        rd(2'd2, v); check("R9 wd2 status", v, 32'h400);
        @(negedge clk);
        reqs("R8 wd held", 32'h0);
        wd_rst = '0;
        @(negedge clk);

        // R9 pin beats watchdog
        rst_pin = 1'b1; wd_rst = 4'b0001;
        @(negedge clk);
        reqs("R8 pin+wd0", 32'h21);
        rd(2'd2, v); check("R9 pin over wd", v, 32'h2);
        rst_pin = 1'b0; wd_rst = '0;
        @(negedge clk);

        // R9 lowest watchdog wins
        wd_rst = 4'b1010;
        @(negedge clk);
        rd(2'd2, v); check("R9 wd1 over wd3", v, 32'h200);
        wd_rst = '0;
        @(negedge clk);

        // R9 watchdog beats software
        wr(2'd0, 32'h0000_5A69);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = 32'h0;
        wd_rst = 4'b0001;
        @(negedge clk);
        bus_we = 1'b0; wd_rst = '0;
        reqs("R5 sw with wd0", 32'h11);
        rd(2'd2, v); check("R9 wd0 over sw", v, 32'h100);
        @(negedge clk);

        // R1 power-on reset mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd(2'd1, v); check("R1 cfg cleared", v, 32'h0);
        rd(2'd2, v); check("R1 status por", v, 32'h1);
        rd(2'd0, v); check("R1 ctrl locked", v, 32'h0001_0003);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule